// File: doc/BRIEF.md
# Timestamped Bus Write Snooper

This block listens passively to a slow parallel peripheral bus: 8 data lines, 4 address lines, and active-low read, write and select strobes. Every write strobe taken while the select line is low becomes one six-byte record. The record holds a fixed sync marker, an elapsed-time word and a snapshot of the bus pins. Records leave the block on a byte-wide ready/valid stream, which can feed a serial link or a capture memory.

The elapsed-time word counts prescaled ticks since the previous qualified write. The default divider turns a 168 MHz clock into ticks of roughly 44.1 kHz. The count clears on every qualified write and holds at its maximum value. The bus inputs are asynchronous and pass through a synchroniser. The pin snapshot is taken in the cycle that detects the falling edge of the synchronised write strobe, while the strobe and select lines are still asserted.

When the output FIFO lacks room for a whole record, the record is discarded as a unit and a sticky overflow flag is raised. A consumer therefore never sees a partial record.

Top module: `bus_snoop`

## Requirements
- R1: After reset, `outValid` is 0 and `overflow` is 0.
- R2: Each qualified write produces exactly six output bytes. The first two bytes are the marker word 0xEEEE.
- R3: A write strobe taken while `busCsN` is high produces no output bytes.
- R4: Every 16-bit word is sent least significant byte first, in the order marker, time, bus word. The bus word is laid out as follows: data in bits 7:0, address in bits 11:8, the read strobe level in bit 12, the select level in bit 13, and zeros in bits 15:14.
- R5: The bus word holds the data and address present when the write falling edge is detected. Later changes while the strobe is still low do not alter it.
- R6: The time word is the number of prescaled ticks (one every `TICK_DIV` clocks) since the previous qualified write. For two writes whose strobes fall k cycles apart, it equals floor((k-1)/`TICK_DIV`). The count clears on every qualified write.
- R7: The tick count saturates at 2^`CNT_W`-1 (65535 by default), zero-extended to 16 bits.
- R8: A qualified write that finds fewer than six free FIFO bytes is dropped whole, and no byte of it appears. `overflow` then rises and stays high until reset.
- R9: While `outValid` is high and `outReady` is low, `outValid` stays high and `outData` holds its value.
- R10: The synchronous active-high `rst` empties the FIFO, clears the tick count and clears `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| busData | input | 8 | Snooped bus data lines |
| busAddr | input | 4 | Snooped bus address lines |
| busRdN | input | 1 | Snooped read strobe, active low |
| busCsN | input | 1 | Snooped chip select, active low |
| busWrN | input | 1 | Snooped write strobe, active low |
| outData | output | 8 | Record byte stream |
| outValid | output | 1 | `outData` holds a byte |
| outReady | input | 1 | Consumer accepts the byte |
| overflow | output | 1 | Sticky flag: a record was dropped |

## Verification
A wrong FIFO count or pointer shows up as a record of other than six bytes, or as a marker pair that is not aligned. Both are visible within the first record read after the fault. A bad prescaler or a missing clear on capture gives a wrong time word in the very next record. A misplaced drop decision shows up when three records are pushed into a full FIFO without draining: it yields either a partial third record or no overflow flag, and this is seen on the thirteenth byte.

// File: rtl/bus_snoop_pkg.sv
package bus_snoop_pkg;
  localparam int REC_BYTES = 6;
  localparam logic [15:0] SYNC_MARK = 16'hEEEE;

  typedef struct packed {
    logic fire;   // qualified write seen this cycle
    logic push;   // record goes into the FIFO
    logic drop;   // record discarded for lack of room
  } snoopStrb_t;
endpackage

// File: rtl/bus_snoop_dp.sv
module bus_snoop_dp
  import bus_snoop_pkg::*;
#(
  parameter int TICK_DIV    = 3810,
  parameter int CNT_W       = 16,
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] busData,
  input  logic [3:0] busAddr,
  input  logic       busRdN,
  input  logic       busCsN,
  input  logic       busWrN,
  input  snoopStrb_t strb,
  output logic       wrFall,
  output logic       csLow,
  output logic       fitsRecord,
  output logic [7:0] outData,
  output logic       outValid,
  input  logic       outReady
);
  localparam int PIN_W = 15;
  localparam int AW    = $clog2(FIFO_DEPTH);
  localparam int DIV_W = $clog2(TICK_DIV + 1);
  localparam logic [PIN_W-1:0] PIN_IDLE = {3'b111, 12'h000};
  localparam logic [CNT_W-1:0] TIME_MAX = '1;
  localparam logic [AW:0] ROOM_LIMIT = (AW+1)'(FIFO_DEPTH - REC_BYTES);

  // input synchroniser
  logic [PIN_W-1:0] pinRaw, pinS;
  logic [PIN_W-1:0] syncReg [SYNC_STAGES];
  logic wrPrev;

  assign pinRaw = {busWrN, busCsN, busRdN, busAddr, busData};
  assign pinS   = syncReg[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncReg[s] <= PIN_IDLE;
      wrPrev <= 1'b1;
    end else begin
      syncReg[0] <= pinRaw;
      for (int s = 1; s < SYNC_STAGES; s++) syncReg[s] <= syncReg[s-1];
      wrPrev <= pinS[14];
    end
  end

  assign wrFall = wrPrev & ~pinS[14];
  assign csLow  = ~pinS[13];

  // tick prescaler and elapsed counter
  logic [DIV_W-1:0] preCnt;
  logic [CNT_W-1:0] timeCnt;

  always_ff @(posedge clk) begin
    if (rst || strb.fire) begin
      preCnt  <= '0;
      timeCnt <= '0;
    end else if (preCnt == DIV_W'(TICK_DIV - 1)) begin
      preCnt <= '0;
      if (timeCnt != TIME_MAX) timeCnt <= timeCnt + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  // record assembly
  logic [15:0] busWord;
  logic [8*REC_BYTES-1:0] recBits;
  assign busWord = {2'b00, pinS[13:0]};
  assign recBits = {busWord, 16'(timeCnt), SYNC_MARK};

  // output FIFO with a record-wide write port
  logic [7:0]    mem [FIFO_DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW:0]   count;
  logic          pop;

  assign outValid   = (count != '0);
  assign outData    = mem[rdPtr];
  assign pop        = outValid & outReady;
  assign fitsRecord = (count <= ROOM_LIMIT);

  always_ff @(posedge clk) begin
    if (strb.push)
      for (int k = 0; k < REC_BYTES; k++)
        mem[wrPtr + AW'(k)] <= recBits[8*k +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.push) wrPtr <= wrPtr + AW'(REC_BYTES);
      if (pop)       rdPtr <= rdPtr + 1'b1;
      count <= count + (strb.push ? (AW+1)'(REC_BYTES) : '0) - (AW+1)'(pop);
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid && $stable(outData)); // R9
  AST_TIME_CLEAR: assert property (@(posedge clk) disable iff (rst)
    strb.fire |=> timeCnt == '0); // R6
  AST_TIME_SAT: assert property (@(posedge clk) disable iff (rst)
    timeCnt == TIME_MAX && !strb.fire |=> timeCnt == TIME_MAX); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= (AW+1)'(FIFO_DEPTH)); // R8
  AST_CS_QUALIFY: assert property (@(posedge clk) disable iff (rst)
    !csLow |-> !strb.push); // R3
  AST_FIFO_EMPTY_RST: assert property (@(posedge clk)
    rst |=> !outValid); // R10
endmodule

// File: rtl/bus_snoop_ctrl.sv
module bus_snoop_ctrl
  import bus_snoop_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wrFall,
  input  logic       csLow,
  input  logic       fitsRecord,
  output snoopStrb_t strb,
  output logic       overflow
);
  always_comb begin
    strb.fire = wrFall & csLow;
    strb.push = strb.fire & fitsRecord;
    strb.drop = strb.fire & ~fitsRecord;
  end

  always_ff @(posedge clk) begin
    if (rst)            overflow <= 1'b0;
    else if (strb.drop) overflow <= 1'b1;
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow); // R8
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (rst)
    strb.drop |=> overflow); // R8
  AST_OVF_RESET: assert property (@(posedge clk)
    rst |=> !overflow); // R10
endmodule

// File: rtl/bus_snoop.sv
module bus_snoop
  import bus_snoop_pkg::*;
#(
  parameter int TICK_DIV    = 3810,
  parameter int CNT_W       = 16,
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] busData,
  input  logic [3:0] busAddr,
  input  logic       busRdN,
  input  logic       busCsN,
  input  logic       busWrN,
  output logic [7:0] outData,
  output logic       outValid,
  input  logic       outReady,
  output logic       overflow
);
  snoopStrb_t strb;
  logic wrFall, csLow, fitsRecord;

  bus_snoop_dp #(
    .TICK_DIV(TICK_DIV), .CNT_W(CNT_W),
    .FIFO_DEPTH(FIFO_DEPTH), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rst(rst),
    .busData(busData), .busAddr(busAddr),
    .busRdN(busRdN), .busCsN(busCsN), .busWrN(busWrN),
    .strb(strb), .wrFall(wrFall), .csLow(csLow), .fitsRecord(fitsRecord),
    .outData(outData), .outValid(outValid), .outReady(outReady)
  );

  bus_snoop_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .wrFall(wrFall), .csLow(csLow), .fitsRecord(fitsRecord),
    .strb(strb), .overflow(overflow)
  );
endmodule

// File: tb/test_bus_snoop.sv
module test_bus_snoop;
  localparam int DIV   = 4;
  localparam int CW    = 6;
  localparam int DEPTH = 16;
  localparam int TMAX  = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] busData = '0;
  logic [3:0] busAddr = '0;
  logic busRdN = 1'b1, busCsN = 1'b1, busWrN = 1'b1;
  logic [7:0] outData;
  logic outValid, overflow;
  logic outReady = 1'b0;

  int checks = 0, fails = 0, cyc = 0;
  int lastFall = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bus_snoop #(.TICK_DIV(DIV), .CNT_W(CW), .FIFO_DEPTH(DEPTH), .SYNC_STAGES(2)) i_bus_snoop (
    .clk(clk), .rst(rst), .busData(busData), .busAddr(busAddr),
    .busRdN(busRdN), .busCsN(busCsN), .busWrN(busWrN),
    .outData(outData), .outValid(outValid), .outReady(outReady),
    .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one strobe; midData changes data after midAt low cycles
  task automatic busWrite(input logic [7:0] d, input logic [3:0] a, input logic rdN,
                          input logic csN, input int lowCycles,
                          input logic [7:0] midData, input int midAt);
    @(negedge clk);
    busData = d; busAddr = a; busRdN = rdN; busCsN = csN;
    @(negedge clk);
    busWrN = 1'b0;
    if (!csN) lastFall = cyc;
    for (int i = 0; i < lowCycles; i++) begin
      @(negedge clk);
      if (i + 1 == midAt) busData = midData;
    end
    busWrN = 1'b1;
    @(negedge clk);
    busCsN = 1'b1; busRdN = 1'b1;
  endtask

  task automatic readByte(output logic [7:0] b, output bit got);
    got = 1'b0;
    for (int w = 0; w < 60 && !outValid; w++) @(negedge clk);
    if (outValid) begin
      b = outData; got = 1'b1;
      outReady = 1'b1;
      @(negedge clk);
      outReady = 1'b0;
    end else b = 8'h00;
  endtask

  task automatic readRecord(output logic [15:0] w0, output logic [15:0] w1,
                            output logic [15:0] w2, output bit got);
    logic [7:0] b [6];
    bit g;
    got = 1'b1;
    for (int i = 0; i < 6; i++) begin
      readByte(b[i], g);
      got &= g;
    end
    w0 = {b[1], b[0]}; w1 = {b[3], b[2]}; w2 = {b[5], b[4]};
  endtask

  task automatic expectIdle(input int n, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (outValid) seen = 1'b1;
    end
    check(!seen, req, 32'(seen), 32'd0);
  endtask

  task automatic tReset();
    check(outValid == 1'b0, "R1 valid after reset", 32'(outValid), 0);
    check(overflow == 1'b0, "R1 overflow after reset", 32'(overflow), 0);
  endtask

  task automatic tBasic();
    logic [15:0] w0, w1, w2; bit got;
    busWrite(8'h3C, 4'h5, 1'b1, 1'b0, 4, 8'h00, 0);
    readRecord(w0, w1, w2, got);
    check(got, "R2 six bytes", 32'(got), 1);
    check(w0 == 16'hEEEE, "R2 marker", 32'(w0), 32'hEEEE);
    check(w2 == 16'h153C, "R4 bus word rd high", 32'(w2), 32'h153C);
    expectIdle(10, "R2 no seventh byte");
  endtask

  task automatic tTiming(input int gap);
    logic [15:0] w0, w1, w2; bit got; int first, k, expT;
    busWrite(8'h11, 4'h1, 1'b1, 1'b0, 3, 8'h00, 0);
    first = lastFall;
    repeat (gap) @(negedge clk);
    busWrite(8'h22, 4'h2, 1'b1, 1'b0, 3, 8'h00, 0);
    k = lastFall - first;
    expT = (k - 1) / DIV;
    if (expT > TMAX) expT = TMAX;
    readRecord(w0, w1, w2, got);
    readRecord(w0, w1, w2, got);
    check(got && w0 == 16'hEEEE, "R6 second record marker", 32'(w0), 32'hEEEE);
    check(w1 == 16'(expT), (expT == TMAX) ? "R7 saturated time" : "R6 elapsed ticks",
          32'(w1), 32'(expT));
  endtask

  task automatic tReadLow();
    logic [15:0] w0, w1, w2; bit got;
    busWrite(8'hA5, 4'hF, 1'b0, 1'b0, 4, 8'h00, 0);
    readRecord(w0, w1, w2, got);
    check(got && w2 == 16'h0FA5, "R4 bus word rd low", 32'(w2), 32'h0FA5);
  endtask

  task automatic tNoSelect();
    busWrite(8'h77, 4'h3, 1'b1, 1'b1, 4, 8'h00, 0);
    expectIdle(20, "R3 unselected write ignored");
  endtask

  task automatic tLateData();
    logic [15:0] w0, w1, w2; bit got;
    busWrite(8'h5A, 4'h6, 1'b1, 1'b0, 8, 8'hC3, 4);
    readRecord(w0, w1, w2, got);
    check(got && w2 == 16'h165A, "R5 data at falling edge", 32'(w2), 32'h165A);
  endtask

  task automatic tOverflow();
    logic [15:0] w0, w1, w2; bit got;
    busWrite(8'h01, 4'h1, 1'b1, 1'b0, 3, 8'h00, 0);
    busWrite(8'h02, 4'h2, 1'b1, 1'b0, 3, 8'h00, 0);
    check(overflow == 1'b0, "R8 no flag while room", 32'(overflow), 0);
    busWrite(8'h03, 4'h3, 1'b1, 1'b0, 3, 8'h00, 0);
    repeat (4) @(negedge clk);
    check(overflow == 1'b1, "R8 flag on drop", 32'(overflow), 1);
    readRecord(w0, w1, w2, got);
    check(got && w0 == 16'hEEEE && w2 == 16'h1101, "R8 first kept", 32'(w2), 32'h1101);
    readRecord(w0, w1, w2, got);
    check(got && w0 == 16'hEEEE && w2 == 16'h1202, "R8 second kept", 32'(w2), 32'h1202);
    expectIdle(20, "R8 dropped record absent");
    check(overflow == 1'b1, "R8 flag sticky", 32'(overflow), 1);
  endtask

  task automatic tHold();
    logic [7:0] first; bit moved = 1'b0;
    busWrite(8'h99, 4'h9, 1'b1, 1'b0, 3, 8'h00, 0);
    repeat (3) @(negedge clk);
    first = outData;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!outValid || outData != first) moved = 1'b1;
    end
    check(!moved, "R9 held while not ready", 32'(moved), 0);
  endtask

  task automatic tResetMid();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(outValid == 1'b0, "R10 FIFO cleared", 32'(outValid), 0);
    check(overflow == 1'b0, "R10 overflow cleared", 32'(overflow), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    tReset();
    tBasic();
    tTiming(20);
    tTiming(0);
    tReadLow();
    tNoSelect();
    tLateData();
    tTiming(300);
    tOverflow();
    tHold();
    tResetMid();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule